// File: doc/BRIEF.md
# I2C Multiplexer Detect-and-Select Sequencer

This block drives an eight-way I2C bus multiplexer through a byte-level I2C master. The byte master owns all bit timing. This block issues it one command at a time: bus start, bus stop, byte write or byte read. It waits for each command to complete before it issues the next.

The block performs two operations. A detect operation first pulses the multiplexer's reset line. It then reads the device's control register at the fixed probe address 0x71. The byte read back tells which of two device variants is fitted: variant A (code 0) or variant B (code 1). The result is latched and shapes every later select.

A select operation writes one control byte to the multiplexer at a caller-supplied 7-bit address. That byte either enables exactly one of the eight downstream channels or switches all of them off. Variant A uses a one-hot channel mask. Variant B uses the channel index with an enable flag. Each operation ends with `done` raised and a 2-bit error code. Both are held until the next request is accepted.

Top module: `i2cmx_seq`

## Requirements
- R1: After reset, `variant` is 0 (variant A), `done` is 0, `err_code` is 0, and `mux_rst` and `bm_go` are low.
- R2: A detect raises `mux_rst` for exactly UNIT_CYCLES clock cycles. It then holds it low for exactly UNIT_CYCLES further cycles before the first byte-master command is issued.
- R3: A detect issues these byte-master commands in order. Op codes are start=0, stop=1, write=2 and read=3. The sequence is start, write of 0xE3, read with `bm_rd_nack` high, and stop.
- R4: A detect read value of 0x00 sets `variant` to 0 and a value of 0x08 sets it to 1, each with `err_code` 0. Any other value gives `err_code` 3 and leaves `variant` unchanged.
- R5: If the address byte is not acknowledged during a detect or a select, the block issues stop as the next command. It then finishes with `err_code` 1.
- R6: A select issues start, then a write of `{mux_addr, 1'b0}`, then a write of the control byte, then stop, and finishes with `err_code` 0.
- R7: With `variant` 0, the control byte is 1 shifted left by `chan`. It is 0x00 when `all_off` is high.
- R8: With `variant` 1, the control byte is `chan` ORed with 0x08. It is 0x00 when `all_off` is high.
- R9: If the control byte is not acknowledged, the block issues stop as the next command. It then finishes with `err_code` 2.
- R10: `done` and `err_code` stay unchanged while no request is applied. `done` falls in the cycle after a request is accepted.
- R11: When `det_req` and `sel_req` are high in the same idle cycle, only the detect is performed. Requests that arrive while an operation is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_req | input | 1 | Request a reset-and-identify operation |
| sel_req | input | 1 | Request a channel-select operation |
| mux_addr | input | 7 | Multiplexer bus address for select |
| chan | input | 3 | Channel to enable |
| all_off | input | 1 | Disable all channels instead of enabling one |
| variant | output | 1 | Latched device variant: 0 = A, 1 = B |
| done | output | 1 | Operation finished; held until next accepted request |
| err_code | output | 2 | 0 ok, 1 address NACK, 2 control NACK, 3 unknown device |
| mux_rst | output | 1 | Reset line to the multiplexer |
| bm_go | output | 1 | One-cycle command strobe to the byte master |
| bm_op | output | 2 | Command op: 0 start, 1 stop, 2 write, 3 read |
| bm_wdata | output | 8 | Byte to write |
| bm_rd_nack | output | 1 | Reply NACK after the byte being read |
| bm_done | input | 1 | Byte master finished the current command |
| bm_ack | input | 1 | Written byte was acknowledged |
| bm_rdata | input | 8 | Byte read from the bus |

## Verification
Two requests can fall in the same cycle: a detect and a select both raised while idle. A request can also arrive in the middle of an operation already running. The bench drives both requests on one edge and checks that the reset pulse appears and that the first written byte is 0xE3. It also raises a detect partway through a select and checks that the command log contains only the four select commands and that no reset pulse occurs.

// File: rtl/i2cmx_pkg.sv
package i2cmx_pkg;

    typedef enum logic [1:0] {
        BM_START = 2'd0,
        BM_STOP  = 2'd1,
        BM_WRITE = 2'd2,
        BM_READ  = 2'd3
    } bm_op_e;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_ADDR_NACK = 2'd1,
        ERR_CTRL_NACK = 2'd2,
        ERR_UNKNOWN   = 2'd3
    } err_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_RST_HI = 3'd1,
        S_RST_LO = 3'd2,
        S_START  = 3'd3,
        S_ADDR   = 3'd4,
        S_DATA   = 3'd5,
        S_STOP   = 3'd6
    } seq_st_e;

endpackage

// File: rtl/i2cmx_unit_timer.sv
module i2cmx_unit_timer #(
    parameter int UNIT_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CW = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign expired = tmr_q.run && (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.cnt = CW'(UNIT_CYCLES - 1);
            tmr_d.run = 1'b1;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R2
    single_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !start) |=> !expired);

endmodule

// File: rtl/i2cmx_id_decode.sv
module i2cmx_id_decode #(
    parameter int          D_W  = 8,
    parameter logic [D_W-1:0] ID_A = 8'h00,
    parameter logic [D_W-1:0] ID_B = 8'h08
) (
    input  logic [D_W-1:0] rdata,
    output logic           known,
    output logic           is_b
);
    logic hit_a;
    logic hit_b;

    always_comb begin
        hit_a = (rdata == ID_A);
        hit_b = (rdata == ID_B);
        known = hit_a || hit_b;
        is_b  = hit_b;
    end

endmodule

// File: rtl/i2cmx_ctrl_enc.sv
module i2cmx_ctrl_enc #(
    parameter int CH_W = 3,
    parameter int D_W  = 8
) (
    input  logic [CH_W-1:0] chan,
    input  logic            all_off,
    input  logic            var_b,
    output logic [D_W-1:0]  word
);
    localparam int NCH = 1 << CH_W;

    logic [D_W-1:0] onehot_w;
    logic [D_W-1:0] index_w;

    for (genvar i = 0; i < D_W; i++) begin : g_onehot
        if (i < NCH) begin : g_live
            assign onehot_w[i] = (chan == CH_W'(i));
        end else begin : g_zero
            assign onehot_w[i] = 1'b0;
        end
    end

    always_comb begin
        index_w        = '0;
        index_w[CH_W-1:0] = chan;
        index_w[CH_W]  = 1'b1;
        if (all_off) begin
            word = '0;
        end else if (var_b) begin
            word = index_w;
        end else begin
            word = onehot_w;
        end
    end

endmodule

// File: rtl/i2cmx_seq.sv
module i2cmx_seq
    import i2cmx_pkg::*;
#(
    parameter int UNIT_CYCLES = 5000,
    parameter int ADDR_W      = 7,
    parameter int CH_W        = 3,
    parameter logic [ADDR_W-1:0] PROBE_ADDR = 7'h71,
    parameter logic [7:0]  ID_A = 8'h00,
    parameter logic [7:0]  ID_B = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              det_req,
    input  logic              sel_req,
    input  logic [ADDR_W-1:0] mux_addr,
    input  logic [CH_W-1:0]   chan,
    input  logic              all_off,
    output logic              variant,
    output logic              done,
    output logic [1:0]        err_code,
    output logic              mux_rst,
    output logic              bm_go,
    output logic [1:0]        bm_op,
    output logic [7:0]        bm_wdata,
    output logic              bm_rd_nack,
    input  logic              bm_done,
    input  logic              bm_ack,
    input  logic [7:0]        bm_rdata
);
    localparam int D_W = ADDR_W + 1;

    typedef struct packed {
        seq_st_e           st;
        logic              waiting;
        logic              det;
        logic [ADDR_W-1:0] addr;
        logic [CH_W-1:0]   ch;
        logic              off;
        logic              var_b;
        logic              done;
        err_e              err;
    } seq_t;

    seq_t s_d, s_q;

    logic           tmr_start;
    logic           tmr_exp;
    logic           id_known;
    logic           id_is_b;
    logic [D_W-1:0] ctrl_word;
    bm_op_e         op_c;

    i2cmx_unit_timer #(.UNIT_CYCLES(UNIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .expired (tmr_exp)
    );

    i2cmx_id_decode #(.D_W(D_W), .ID_A(ID_A), .ID_B(ID_B)) u_id (
        .rdata (bm_rdata),
        .known (id_known),
        .is_b  (id_is_b)
    );

    i2cmx_ctrl_enc #(.CH_W(CH_W), .D_W(D_W)) u_enc (
        .chan    (s_q.ch),
        .all_off (s_q.off),
        .var_b   (s_q.var_b),
        .word    (ctrl_word)
    );

    // Command selection per bus phase
    always_comb begin
        case (s_q.st)
            S_START: op_c = BM_START;
            S_ADDR:  op_c = BM_WRITE;
            S_DATA:  op_c = s_q.det ? BM_READ : BM_WRITE;
            default: op_c = BM_STOP;
        endcase
    end

    always_comb begin
        bm_wdata = '0;
        if (s_q.st == S_ADDR) begin
            bm_wdata = s_q.det ? {PROBE_ADDR, 1'b1} : {s_q.addr, 1'b0};
        end else if (s_q.st == S_DATA && !s_q.det) begin
            bm_wdata = ctrl_word;
        end
    end

    // Next-state logic
    always_comb begin
        s_d       = s_q;
        tmr_start = 1'b0;
        bm_go     = 1'b0;
        case (s_q.st)
            S_IDLE: begin
                if (det_req || sel_req) begin
                    s_d.det  = det_req;
                    s_d.addr = mux_addr;
                    s_d.ch   = chan;
                    s_d.off  = all_off;
                    s_d.done = 1'b0;
                    s_d.err  = ERR_NONE;
                    if (det_req) begin
                        s_d.st    = S_RST_HI;
                        tmr_start = 1'b1;
                    end else begin
                        s_d.st = S_START;
                    end
                end
            end
            S_RST_HI: begin
                if (tmr_exp) begin
                    s_d.st    = S_RST_LO;
                    tmr_start = 1'b1;
                end
            end
            S_RST_LO: begin
                if (tmr_exp) begin
                    s_d.st = S_START;
                end
            end
            default: begin
                if (!s_q.waiting) begin
                    bm_go       = 1'b1;
                    s_d.waiting = 1'b1;
                end else if (bm_done) begin
                    s_d.waiting = 1'b0;
                    case (s_q.st)
                        S_START: s_d.st = S_ADDR;
                        S_ADDR: begin
                            s_d.st = bm_ack ? S_DATA : S_STOP;
                            if (!bm_ack) begin
                                s_d.err = ERR_ADDR_NACK;
                            end
                        end
                        S_DATA: begin
                            s_d.st = S_STOP;
                            if (s_q.det) begin
                                if (id_known) begin
                                    s_d.var_b = id_is_b;
                                end else begin
                                    s_d.err = ERR_UNKNOWN;
                                end
                            end else if (!bm_ack) begin
                                s_d.err = ERR_CTRL_NACK;
                            end
                        end
                        default: begin
                            s_d.st   = S_IDLE;
                            s_d.done = 1'b1;
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= S_IDLE;
            s_q.err   <= ERR_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign variant    = s_q.var_b;
    assign done       = s_q.done;
    assign err_code   = s_q.err;
    assign mux_rst    = (s_q.st == S_RST_HI);
    assign bm_op      = op_c;
    assign bm_rd_nack = (s_q.st == S_DATA) && s_q.det;

    // R2
    rst_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mux_rst |-> !bm_go);

    // R3
    go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bm_go |=> !bm_go);

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !det_req && !sel_req) |=> (done && $stable(err_code)));

    // R10
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (det_req || sel_req)) |=> !done);

    // R4
    variant_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(variant) |-> $past(bm_done));

    // R11
    reset_only_on_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mux_rst) |-> $past(det_req));

endmodule

// File: tb/i2cmx_seq_tb.sv
module i2cmx_seq_tb_top;
    localparam int U   = 4;
    localparam int LAT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       det_req = 1'b0, sel_req = 1'b0;
    logic [6:0] mux_addr = '0;
    logic [2:0] chan = '0;
    logic       all_off = 1'b0;
    logic       variant, done, mux_rst, bm_go, bm_rd_nack;
    logic [1:0] err_code, bm_op;
    logic [7:0] bm_wdata;
    logic       bm_done = 1'b0, bm_ack = 1'b0;
    logic [7:0] bm_rdata = '0;

    always #10 clk = ~clk;

    i2cmx_seq #(.UNIT_CYCLES(U)) dut_i (
        .clk(clk), .rst_n(rst_n), .det_req(det_req), .sel_req(sel_req),
        .mux_addr(mux_addr), .chan(chan), .all_off(all_off),
        .variant(variant), .done(done), .err_code(err_code), .mux_rst(mux_rst),
        .bm_go(bm_go), .bm_op(bm_op), .bm_wdata(bm_wdata), .bm_rd_nack(bm_rd_nack),
        .bm_done(bm_done), .bm_ack(bm_ack), .bm_rdata(bm_rdata)
    );

    int checks = 0, fails = 0, cyc = 0;
    // byte-master model state
    logic [1:0] op_log [8];
    logic [7:0] dat_log [8];
    logic       nk_log [8];
    int  log_n = 0, wr_idx = 0, pend = 0;
    logic nack_addr = 1'b0, nack_ctrl = 1'b0;
    logic [7:0] rd_val = '0;
    int  rst_hi_n = 0, last_rst = -1, first_go = -1;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        bm_done <= 1'b0;
        if (mux_rst) begin
            rst_hi_n <= rst_hi_n + 1;
            last_rst <= cyc;
        end
        if (pend > 0) begin
            if (pend == 1) begin
                bm_done <= 1'b1;
                bm_rdata <= rd_val;
                if (op_log[log_n-1] == 2'd2)
                    bm_ack <= (wr_idx == 1) ? !nack_addr : !nack_ctrl;
                else
                    bm_ack <= 1'b1;
            end
            pend <= pend - 1;
        end
        if (bm_go) begin
            if (first_go < 0) first_go <= cyc;
            if (log_n < 8) begin
                op_log[log_n]  <= bm_op;
                dat_log[log_n] <= bm_wdata;
                nk_log[log_n]  <= bm_rd_nack;
            end
            log_n <= log_n + 1;
            if (bm_op == 2'd0) wr_idx <= 0;
            if (bm_op == 2'd2) wr_idx <= wr_idx + 1;
            pend <= LAT;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clr_log();
        log_n = 0; rst_hi_n = 0; last_rst = -1; first_go = -1;
    endtask

    task automatic run(input bit d, input bit s, input logic [6:0] a,
                       input logic [2:0] c, input logic off);
        int t;
        @(negedge clk);
        clr_log();
        det_req = d; sel_req = s; mux_addr = a; chan = c; all_off = off;
        @(negedge clk);
        det_req = 0; sel_req = 0;
        t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(done, "R10_done_reached", done, 1);
    endtask

    task automatic chk_seq4(input string req, input logic [7:0] b1, input logic [7:0] b2,
                            input logic [1:0] op2);
        chk(log_n == 4, req, log_n, 4);
        if (log_n == 4) begin
            chk(op_log[0] == 2'd0, req, op_log[0], 0);
            chk(op_log[1] == 2'd2 && dat_log[1] == b1, req, dat_log[1], b1);
            chk(op_log[2] == op2, req, op_log[2], op2);
            if (op2 == 2'd2) chk(dat_log[2] == b2, req, dat_log[2], b2);
            else chk(nk_log[2] == 1'b1, req, nk_log[2], 1);
            chk(op_log[3] == 2'd1, req, op_log[3], 1);
        end
    endtask

    initial begin
        logic exp_var;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(variant == 0 && done == 0 && err_code == 0 && !mux_rst && !bm_go,
            "R1_reset", {variant, done, err_code, mux_rst, bm_go}, 0);

        // R2 R3 R4: detect variant B
        rd_val = 8'h08;
        run(1, 0, 7'h00, 3'd0, 0);
        chk(rst_hi_n == U, "R2_rst_width", rst_hi_n, U);
        chk(first_go - last_rst - 1 == U, "R2_rst_gap", first_go - last_rst - 1, U);
        chk_seq4("R3_detect_seq", 8'hE3, 8'h00, 2'd3);
        chk(variant == 1 && err_code == 0, "R4_var_b", {variant, err_code}, 4);

        // R6 R8: select sweep with variant B
        for (int ch = 0; ch < 8; ch++) begin
            for (int off = 0; off < 2; off++) begin
                logic [7:0] w;
                w = off ? 8'h00 : (8'(ch) | 8'h08);
                run(0, 1, 7'(7'h68 + ch), 3'(ch), 1'(off));
                chk_seq4("R8_sel_b", {7'(7'h68 + ch), 1'b0}, w, 2'd2);
                chk(err_code == 0, "R6_sel_ok", err_code, 0);
            end
        end

        // R4: detect sweep over every read value
        exp_var = 1'b1;
        for (int v = 0; v < 256; v++) begin
            rd_val = 8'(v);
            run(1, 0, 7'h00, 3'd0, 0);
            if (v == 0) exp_var = 1'b0;
            else if (v == 8) exp_var = 1'b1;
            chk(variant == exp_var, "R4_variant", variant, exp_var);
            chk(err_code == ((v == 0 || v == 8) ? 2'd0 : 2'd3), "R4_err",
                err_code, (v == 0 || v == 8) ? 0 : 3);
            chk(log_n == 4 && op_log[3] == 2'd1, "R4_stop", log_n, 4);
        end
        rd_val = 8'h00;
        run(1, 0, 7'h00, 3'd0, 0);
        chk(variant == 0, "R4_back_to_a", variant, 0);

        // R6 R7: select sweep with variant A
        for (int ch = 0; ch < 8; ch++) begin
            for (int off = 0; off < 2; off++) begin
                logic [7:0] w;
                w = off ? 8'h00 : (8'h01 << ch);
                run(0, 1, 7'(7'h70 + ch), 3'(ch), 1'(off));
                chk_seq4("R7_sel_a", {7'(7'h70 + ch), 1'b0}, w, 2'd2);
                chk(err_code == 0, "R6_sel_ok", err_code, 0);
            end
        end

        // R5: address NACK on detect and on select
        nack_addr = 1'b1;
        rd_val = 8'h08;
        run(1, 0, 7'h00, 3'd0, 0);
        chk(err_code == 1, "R5_det_err", err_code, 1);
        chk(log_n == 3 && op_log[2] == 2'd1, "R5_det_stop", log_n, 3);
        chk(variant == 0, "R5_var_kept", variant, 0);
        run(0, 1, 7'h55, 3'd2, 0);
        chk(err_code == 1, "R5_sel_err", err_code, 1);
        chk(log_n == 3 && op_log[2] == 2'd1, "R5_sel_stop", log_n, 3);
        nack_addr = 1'b0;

        // R9: control word NACK
        nack_ctrl = 1'b1;
        run(0, 1, 7'h55, 3'd5, 0);
        chk(err_code == 2, "R9_err", err_code, 2);
        chk_seq4("R9_seq", 8'hAA, 8'h20, 2'd2);
        nack_ctrl = 1'b0;

        // R10: hold, then clear on acceptance
        repeat (10) @(negedge clk);
        chk(done == 1 && err_code == 2, "R10_hold", {done, err_code}, 6);
        sel_req = 1'b1; mux_addr = 7'h11; chan = 3'd1; all_off = 1'b0;
        clr_log();
        @(negedge clk);
        sel_req = 1'b0;
        chk(done == 0 && err_code == 0, "R10_clear", {done, err_code}, 0);
        while (!done) @(negedge clk);

        // R11: simultaneous requests, detect wins
        rd_val = 8'h08;
        run(1, 1, 7'h22, 3'd3, 0);
        chk(rst_hi_n == U, "R11_det_wins_rst", rst_hi_n, U);
        chk_seq4("R11_det_wins_seq", 8'hE3, 8'h00, 2'd3);
        chk(variant == 1, "R11_var", variant, 1);

        // R11: request during a running select is ignored
        @(negedge clk);
        clr_log();
        sel_req = 1'b1; mux_addr = 7'h33; chan = 3'd6; all_off = 1'b0;
        @(negedge clk);
        sel_req = 1'b0;
        repeat (3) @(negedge clk);
        det_req = 1'b1;
        @(negedge clk);
        det_req = 1'b0;
        while (!done) @(negedge clk);
        repeat (U * 3) @(negedge clk);
        chk(rst_hi_n == 0, "R11_busy_no_rst", rst_hi_n, 0);
        chk_seq4("R11_busy_seq", {7'h33, 1'b0}, 8'h0E, 2'd2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule